// File: doc/BRIEF.md
# I/O Register Space Access Unit

This block models the register-space side of a small microcontroller. A simplified request port, driven by the CPU side, presents one access per clock. Each access is one of seven operations: short-form register read or write, data-space load or store, single-bit set, single-bit clear, or single-bit test. The unit decides whether the access is legal for its address, maps the address to a location, and applies the operation bit-exactly. Behind the decoder sit three general-purpose storage registers, a status register whose flags software clears by writing ones, and a control register with six implemented bits.

A data-space address from 0x20 up to 0x5F is the short-form location 0x20 below it. Data addresses from 0x60 to 0xFF form an extended region that only loads and stores can reach. Bit operations reach only locations 0x00 to 0x1F. Bit set and bit clear touch only the named bit and never rewrite the other bits, so they are safe on the status register: a bit set clears only that one flag, and no other pending flag is lost. A hardware input sets status flags to stand in for peripheral events, and it takes priority over a software clear of the same flag in the same cycle.

Every response is registered and appears on the clock after the request. It carries read data, a single test bit and an illegal-access flag.

Top module: `ioreg_space`

## Requirements
- R1: `req_op` codes are 0 short read, 1 short write, 2 data load, 3 data store, 4 bit set, 5 bit clear, 6 bit test, and 7 is reserved and always illegal. Every cycle with `req_valid` high produces `resp_valid` high on the next cycle, and an idle cycle produces `resp_valid` low.
- R2: Bit set, clear and test are legal only for addresses 0x00 to 0x1F. Any other address gives `resp_illegal` high and changes nothing.
- R3: Short read and write are legal only for addresses 0x00 to 0x3F. Any other address gives `resp_illegal` high and changes nothing.
- R4: A load or store at data address A (0x20 to 0x5F) reaches short location A−0x20. A data address below 0x20 is illegal.
- R5: A general-purpose register at data address 0x84 (extended region, 0x60 to 0xFF) is reachable by load and store only. Short and bit accesses cannot reach any extended location.
- R6: The status register is at location 0x0A. A full write clears each flag whose written bit is 1 and keeps each flag whose written bit is 0.
- R7: Bit set and bit clear change only bit `req_bit` of the target. On the status register, bit set clears only that flag and bit clear has no effect.
- R8: The general-purpose registers at locations 0x05 and 0x2C, and at data address 0x84, are plain 8-bit read/write storage. Location 0x05 is bit-addressable.
- R9: A write to an unmapped location has no effect and is not illegal. A read of one returns 0x00. The control register at location 0x12 implements bits 5..0 only, and bits 7..6 read 0.
- R10: Each bit of `hw_flag_set` that is high sets that status flag, even if a software clear hits the same flag in the same cycle.
- R11: Bit test returns the addressed bit's value on `resp_bit` and changes no register. `resp_data` is 0x00 for every access that is not a legal read.
- R12: A synchronous active-high `rst` clears every register to 0x00 and drives `resp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | 8 | Short location or data address |
| req_bit | input | 3 | Bit index for bit operations |
| req_wdata | input | 8 | Write data |
| hw_flag_set | input | 8 | Hardware flag-set events |
| resp_valid | output | 1 | Response present |
| resp_illegal | output | 1 | Request was rejected |
| resp_data | output | 8 | Read data |
| resp_bit | output | 1 | Bit test result |

## Verification
Full writes are applied over both short and data addresses. Reading the same register back through the other address form checks that the two forms alias each other. Bit set and bit clear are tried on a plain register, on the control register's reserved bits and on the status register with other flags pending. These cases separate a true single-bit update from a read-modify-write that would also clear the other pending flags. Each operation is also sent to an address just outside its legal range and to the extended region, and hardware set events are made to collide with software clears, to check the legality limits and the set-wins priority.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int BIT_W    = $clog2(DATA_W);
    localparam int GP_COUNT = 3;

    localparam logic [ADDR_W-1:0] BIT_OP_TOP  = 8'h1F;
    localparam logic [ADDR_W-1:0] SHORT_TOP   = 8'h3F;
    localparam logic [ADDR_W-1:0] DATA_OFFSET = 8'h20;
    localparam logic [ADDR_W-1:0] EXT_BASE    = 8'h60;

    localparam logic [ADDR_W-1:0] GP_LOC [GP_COUNT] = '{8'h05, 8'h2C, 8'h84};
    localparam logic [ADDR_W-1:0] FLAG_LOC  = 8'h0A;
    localparam logic [ADDR_W-1:0] CTRL_LOC  = 8'h12;
    localparam logic [DATA_W-1:0] CTRL_IMPL = 8'h3F;

    typedef enum logic [2:0] {
        OP_SHORT_RD = 3'd0,
        OP_SHORT_WR = 3'd1,
        OP_LOAD     = 3'd2,
        OP_STORE    = 3'd3,
        OP_BSET     = 3'd4,
        OP_BCLR     = 3'd5,
        OP_BTEST    = 3'd6,
        OP_RSVD     = 3'd7
    } op_e;

    typedef struct packed {
        logic                legal;
        logic                is_read;
        logic                is_full_wr;
        logic                is_bset;
        logic                is_bclr;
        logic                is_test;
        logic [GP_COUNT-1:0] gp_hit;
        logic                flag_hit;
        logic                ctrl_hit;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] val;
        logic [DATA_W-1:0] clr;
    } wr_t;

    function automatic dec_t decode_req(logic [2:0] op, logic [ADDR_W-1:0] addr);
        dec_t d;
        logic [ADDR_W-1:0] loc;
        d   = '0;
        loc = addr;
        case (op_e'(op))
            OP_SHORT_RD, OP_SHORT_WR: begin
                d.legal      = (addr <= SHORT_TOP);
                d.is_read    = (op_e'(op) == OP_SHORT_RD);
                d.is_full_wr = (op_e'(op) == OP_SHORT_WR);
            end
            OP_LOAD, OP_STORE: begin
                d.legal      = (addr >= DATA_OFFSET);
                d.is_read    = (op_e'(op) == OP_LOAD);
                d.is_full_wr = (op_e'(op) == OP_STORE);
                loc          = (addr >= EXT_BASE) ? addr : addr - DATA_OFFSET;
            end
            OP_BSET, OP_BCLR, OP_BTEST: begin
                d.legal   = (addr <= BIT_OP_TOP);
                d.is_bset = (op_e'(op) == OP_BSET);
                d.is_bclr = (op_e'(op) == OP_BCLR);
                d.is_test = (op_e'(op) == OP_BTEST);
            end
            default: d.legal = 1'b0;
        endcase
        if (d.legal) begin
            for (int i = 0; i < GP_COUNT; i++) begin
                d.gp_hit[i] = (loc == GP_LOC[i]);
            end
            d.flag_hit = (loc == FLAG_LOC);
            d.ctrl_hit = (loc == CTRL_LOC);
        end
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] bit_onehot(logic [BIT_W-1:0] idx);
        return DATA_W'(1) << idx;
    endfunction

endpackage

// File: rtl/ioreg_decode.sv
module ioreg_decode
    import ioreg_pkg::*;
(
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [BIT_W-1:0]    req_bit,
    input  logic [DATA_W-1:0]   req_wdata,
    output dec_t                dec,
    output wr_t                 wr,
    output logic                wr_go
);

    dec_t raw;

    always_comb begin
        raw = decode_req(req_op, req_addr);
        dec = raw;
        if (!req_valid) begin
            dec = '0;
        end
    end

    always_comb begin
        wr = '0;
        if (dec.is_full_wr) begin
            wr.mask = '1;
            wr.val  = req_wdata;
            wr.clr  = req_wdata;
        end else if (dec.is_bset) begin
            wr.mask = bit_onehot(req_bit);
            wr.val  = '1;
            wr.clr  = bit_onehot(req_bit);
        end else if (dec.is_bclr) begin
            wr.mask = bit_onehot(req_bit);
            wr.val  = '0;
            wr.clr  = '0;
        end
    end

    assign wr_go = dec.legal & (dec.is_full_wr | dec.is_bset | dec.is_bclr);

endmodule

// File: rtl/ioreg_gp_bank.sv
module ioreg_gp_bank #(
    parameter int N     = 3,
    parameter int WIDTH = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N-1:0]            we,
    input  logic [WIDTH-1:0]        mask,
    input  logic [WIDTH-1:0]        val,
    output logic [N-1:0][WIDTH-1:0] q
);

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[g] <= '0;
            end else if (we[g]) begin
                q[g] <= (q[g] & ~mask) | (val & mask);
            end
        end
    end

endmodule

// File: rtl/ioreg_ctrl_reg.sv
module ioreg_ctrl_reg #(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] IMPL  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [WIDTH-1:0] mask,
    input  logic [WIDTH-1:0] val,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] eff_mask;
    assign eff_mask = mask & IMPL;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= (q & ~eff_mask) | (val & eff_mask);
        end
    end

endmodule

// File: rtl/ioreg_flag_reg.sv
module ioreg_flag_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_mask,
    input  logic [WIDTH-1:0] hw_set,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] kill;
    assign kill = clr_en ? clr_mask : '0;

    // set term applied last so a same-cycle event survives a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= (q & ~kill) | hw_set;
        end
    end

endmodule

// File: rtl/ioreg_space.sv
module ioreg_space
    import ioreg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [2:0]  req_op,
    input  logic [7:0]  req_addr,
    input  logic [2:0]  req_bit,
    input  logic [7:0]  req_wdata,
    input  logic [7:0]  hw_flag_set,
    output logic        resp_valid,
    output logic        resp_illegal,
    output logic [7:0]  resp_data,
    output logic        resp_bit
);

    dec_t                          dec;
    wr_t                           wr;
    logic                          wr_go;
    logic [GP_COUNT-1:0][DATA_W-1:0] gp_q;
    logic [GP_COUNT-1:0]           gp_we;
    logic [DATA_W-1:0]             ctrl_q;
    logic [DATA_W-1:0]             flag_q;
    logic [DATA_W-1:0]             sel_val;

    ioreg_decode u_dec (
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_bit   (req_bit),
        .req_wdata (req_wdata),
        .dec       (dec),
        .wr        (wr),
        .wr_go     (wr_go)
    );

    assign gp_we = wr_go ? dec.gp_hit : '0;

    ioreg_gp_bank #(.N(GP_COUNT), .WIDTH(DATA_W)) u_gp (
        .clk  (clk),
        .rst  (rst),
        .we   (gp_we),
        .mask (wr.mask),
        .val  (wr.val),
        .q    (gp_q)
    );

    ioreg_ctrl_reg #(.WIDTH(DATA_W), .IMPL(CTRL_IMPL)) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_go & dec.ctrl_hit),
        .mask (wr.mask),
        .val  (wr.val),
        .q    (ctrl_q)
    );

    ioreg_flag_reg #(.WIDTH(DATA_W)) u_flag (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (wr_go & dec.flag_hit),
        .clr_mask (wr.clr),
        .hw_set   (hw_flag_set),
        .q        (flag_q)
    );

    always_comb begin
        sel_val = '0;
        for (int i = 0; i < GP_COUNT; i++) begin
            if (dec.gp_hit[i]) sel_val = sel_val | gp_q[i];
        end
        if (dec.ctrl_hit) sel_val = sel_val | ctrl_q;
        if (dec.flag_hit) sel_val = sel_val | flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid   <= 1'b0;
            resp_illegal <= 1'b0;
            resp_data    <= '0;
            resp_bit     <= 1'b0;
        end else begin
            resp_valid   <= req_valid;
            resp_illegal <= req_valid & ~dec.legal;
            resp_data    <= (dec.legal & dec.is_read) ? sel_val : '0;
            resp_bit     <= dec.legal & dec.is_test & sel_val[req_bit];
        end
    end

endmodule

// File: rtl/ioreg_space_chk.sv
module ioreg_space_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [2:0] req_op,
    input logic [7:0] req_addr,
    input logic [7:0] hw_flag_set,
    input logic       resp_valid,
    input logic       resp_illegal,
    input logic [7:0] resp_data,
    input logic [7:0] flag_q,
    input logic [7:0] ctrl_q
);

    a_r1_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !resp_valid);

    a_r2_bit_range: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op >= 3'd4 && req_op <= 3'd6 && req_addr > 8'h1F) |=> resp_illegal);

    a_r3_short_range: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op <= 3'd1 && req_addr > 8'h3F) |=> resp_illegal);

    a_r9_ctrl_reserved: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[7:6] == 2'b00);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (hw_flag_set != 8'h00) |=> ((flag_q & $past(hw_flag_set)) == $past(hw_flag_set)));

    a_r11_test_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd6 && hw_flag_set == 8'h00) |=> $stable(flag_q));

    a_r11_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        resp_illegal |-> (resp_data == 8'h00));

endmodule

bind ioreg_space ioreg_space_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_addr     (req_addr),
    .hw_flag_set  (hw_flag_set),
    .resp_valid   (resp_valid),
    .resp_illegal (resp_illegal),
    .resp_data    (resp_data),
    .flag_q       (flag_q),
    .ctrl_q       (ctrl_q)
);

// File: tb/ioreg_space_test.sv
module ioreg_space_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_op = '0;
    logic [7:0] req_addr = '0;
    logic [2:0] req_bit = '0;
    logic [7:0] req_wdata = '0;
    logic [7:0] hw_flag_set = '0;
    logic       resp_valid, resp_illegal, resp_bit;
    logic [7:0] resp_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 0;

    localparam logic [2:0] RD = 3'd0, WR = 3'd1, LD = 3'd2, ST = 3'd3,
                           BS = 3'd4, BC = 3'd5, BT = 3'd6, RV = 3'd7;

    logic       g_valid, g_illegal, g_bit;
    logic [7:0] g_data;

    always #5 clk = ~clk;

    ioreg_space uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_bit(req_bit), .req_wdata(req_wdata),
        .hw_flag_set(hw_flag_set), .resp_valid(resp_valid),
        .resp_illegal(resp_illegal), .resp_data(resp_data), .resp_bit(resp_bit)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    // drive at negedge, response visible at the following negedge
    task automatic req(input logic [2:0] op, input logic [7:0] a,
                       input logic [2:0] b, input logic [7:0] d, input logic [7:0] hw);
        req_valid = 1'b1; req_op = op; req_addr = a; req_bit = b;
        req_wdata = d; hw_flag_set = hw;
        @(negedge clk);
        g_valid = resp_valid; g_illegal = resp_illegal;
        g_data = resp_data; g_bit = resp_bit;
        req_valid = 1'b0; hw_flag_set = '0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag, input logic [7:0] exp);
        req(RD, a, 3'd0, 8'h00, 8'h00);
        check(tag, g_data, exp);
    endtask

    task automatic t_reset;
        check("R12 resp_valid after reset", {7'b0, resp_valid}, 8'h00);
        rd(8'h05, "R12 gp0 reset", 8'h00);
        rd(8'h0A, "R12 flags reset", 8'h00);
        rd(8'h12, "R12 ctrl reset", 8'h00);
        @(negedge clk);
        check("R1 idle gives no response", {7'b0, resp_valid}, 8'h00);
    endtask

    task automatic t_gp_alias;
        req(WR, 8'h05, 3'd0, 8'hA5, 8'h00);
        check("R1 write response valid", {7'b0, g_valid}, 8'h01);
        rd(8'h05, "R8 gp0 short readback", 8'hA5);
        req(ST, 8'h4C, 3'd0, 8'h3C, 8'h00);
        rd(8'h2C, "R4 store 0x4C aliases loc 0x2C", 8'h3C);
        req(LD, 8'h25, 3'd0, 8'h00, 8'h00);
        check("R4 load 0x25 aliases loc 0x05", g_data, 8'hA5);
        req(LD, 8'h10, 3'd0, 8'h00, 8'h00);
        check("R4 data address below 0x20 illegal", {7'b0, g_illegal}, 8'h01);
    endtask

    task automatic t_extended;
        req(ST, 8'h84, 3'd0, 8'h5A, 8'h00);
        req(LD, 8'h84, 3'd0, 8'h00, 8'h00);
        check("R5 extended load", g_data, 8'h5A);
        req(RD, 8'h84, 3'd0, 8'h00, 8'h00);
        check("R3 short read above 0x3F illegal", {7'b0, g_illegal}, 8'h01);
        check("R11 illegal read data zero", g_data, 8'h00);
        req(WR, 8'h84, 3'd0, 8'hFF, 8'h00);
        check("R3 short write above 0x3F illegal", {7'b0, g_illegal}, 8'h01);
        req(BS, 8'h84, 3'd0, 8'h00, 8'h00);
        check("R2 bit set on extended illegal", {7'b0, g_illegal}, 8'h01);
        req(LD, 8'h84, 3'd0, 8'h00, 8'h00);
        check("R5 extended unchanged by short/bit", g_data, 8'h5A);
    endtask

    task automatic t_bitops;
        req(WR, 8'h05, 3'd0, 8'h00, 8'h00);
        req(BS, 8'h05, 3'd3, 8'h00, 8'h00);
        rd(8'h05, "R7 set bit3", 8'h08);
        req(BS, 8'h05, 3'd7, 8'h00, 8'h00);
        rd(8'h05, "R7 set bit7", 8'h88);
        req(BC, 8'h05, 3'd3, 8'h00, 8'h00);
        rd(8'h05, "R7 clear bit3", 8'h80);
        req(BS, 8'h12, 3'd6, 8'h00, 8'h00);
        rd(8'h12, "R9 ctrl reserved bit6 stays 0", 8'h00);
        req(BS, 8'h12, 3'd2, 8'h00, 8'h00);
        rd(8'h12, "R7 ctrl set bit2", 8'h04);
        req(WR, 8'h12, 3'd0, 8'hFF, 8'h00);
        rd(8'h12, "R9 ctrl full write masked", 8'h3F);
        req(BS, 8'h2C, 3'd0, 8'h00, 8'h00);
        check("R2 bit set at 0x2C illegal", {7'b0, g_illegal}, 8'h01);
        rd(8'h2C, "R2 illegal bit set no effect", 8'h3C);
    endtask

    task automatic t_flags;
        req(RD, 8'h00, 3'd0, 8'h00, 8'hF0);
        rd(8'h0A, "R10 hardware set flags", 8'hF0);
        req(WR, 8'h0A, 3'd0, 8'h30, 8'h00);
        rd(8'h0A, "R6 write ones clears", 8'hC0);
        req(WR, 8'h0A, 3'd0, 8'h00, 8'h00);
        rd(8'h0A, "R6 write zero keeps", 8'hC0);
        req(BS, 8'h0A, 3'd7, 8'h00, 8'h00);
        rd(8'h0A, "R7 bit set clears one flag only", 8'h40);
        req(BC, 8'h0A, 3'd6, 8'h00, 8'h00);
        rd(8'h0A, "R7 bit clear on flags no effect", 8'h40);
    endtask

    task automatic t_test;
        req(BT, 8'h0A, 3'd6, 8'h00, 8'h00);
        check("R11 test set bit", {7'b0, g_bit}, 8'h01);
        check("R11 test data zero", g_data, 8'h00);
        req(BT, 8'h0A, 3'd0, 8'h00, 8'h00);
        check("R11 test clear bit", {7'b0, g_bit}, 8'h00);
        req(BT, 8'h05, 3'd7, 8'h00, 8'h00);
        check("R11 test gp0 bit7", {7'b0, g_bit}, 8'h01);
        rd(8'h0A, "R11 test no side effect", 8'h40);
        req(BT, 8'h20, 3'd0, 8'h00, 8'h00);
        check("R2 test above 0x1F illegal", {7'b0, g_illegal}, 8'h01);
    endtask

    task automatic t_collide;
        req(WR, 8'h0A, 3'd0, 8'h40, 8'h40);
        rd(8'h0A, "R10 set wins over full clear", 8'h40);
        req(BS, 8'h0A, 3'd6, 8'h00, 8'h40);
        rd(8'h0A, "R10 set wins over bit clear", 8'h40);
        req(WR, 8'h0A, 3'd0, 8'h40, 8'h01);
        rd(8'h0A, "R10 other flag cleared, event kept", 8'h01);
    endtask

    task automatic t_reserved;
        req(WR, 8'h30, 3'd0, 8'hFF, 8'h00);
        check("R9 reserved write not illegal", {7'b0, g_illegal}, 8'h00);
        rd(8'h30, "R9 reserved read zero", 8'h00);
        req(RV, 8'h05, 3'd0, 8'hFF, 8'h00);
        check("R1 op 7 illegal", {7'b0, g_illegal}, 8'h01);
        rd(8'h05, "R1 op 7 no effect", 8'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_gp_alias;
        t_extended;
        t_bitops;
        t_flags;
        t_test;
        t_collide;
        t_reserved;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule